// File: doc/BRIEF.md
# Atomic Guard Swap Serializer

This block keeps a small pool of guard cells. Each allocated guard stores one tail pointer: the pointer to the most recent element of an ordered stream of transaction requests. Several requesters share the unit. Each requester may ask to create a guard or to swap a guard's pointer. A round-robin arbiter picks at most one request per cycle. The unit then carries that request out against the guard cells in a single step.

A swap puts the requester's new tail pointer into the guard and hands back the pointer the guard held before. The requester then links that old tail to its new element; the linking write is not part of this block. A create hands back the index of a newly allocated guard, and that guard starts with a null tail. Every guard lives only here, so no copy of a guard exists anywhere else. Swaps from different requesters on the same guard can be granted in consecutive cycles. Each of them sees the value left by the swap before it.

The response logic is a two-state machine. In `RSP_IDLE` no response is being shown. In `RSP_HOLD` a response is shown for exactly one cycle. The transition `IDLE->HOLD` or `HOLD->HOLD` happens on any grant. The transition `HOLD->IDLE` or `IDLE->IDLE` happens when no request is granted.

Top module: `guard_swap_unit`

## Requirements
- R1: After reset no guard is allocated (`guard_alloc` all zero), `guards_full` is low and `rsp_valid` is all zero.
- R2: A granted create (`req_create`=1) allocates the lowest-numbered free guard. One cycle after the grant, the response has `rsp_ok`=1 and `rsp_data` equal to that guard index, zero-extended. The matching `guard_alloc` bit goes high.
- R3: A freshly created guard holds the null pointer (all zeros), so the first swap on it returns 0.
- R4: A granted swap (`req_create`=0) on an allocated guard returns `rsp_ok`=1 with the previously stored pointer. It then stores the requester's `req_ptr` as the new tail.
- R5: Swaps from different requesters on one guard that are granted in consecutive cycles each return the pointer written by the swap granted just before.
- R6: At most one request is granted per cycle (`req_ready` is one-hot or zero). `rsp_valid` is one-hot on the bit of the granted requester, exactly one cycle after the grant, and zero in cycles that follow no grant.
- R7: Arbitration is round-robin. After requester i is granted, requester (i+1) mod NREQ has the highest priority, and priority then falls in increasing index order with wrap-around. After reset, requester 0 has the highest priority.
- R8: A swap on an unallocated guard responds with `rsp_ok`=0 and `rsp_data`=0. It changes no guard and no allocation bit.
- R9: While all guards are allocated, `guards_full` is high and create requests get no `req_ready` and no grant. Swap requests are still granted in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_create | input | NREQ | 1 = create guard, 0 = swap |
| req_guard | input | NREQ x GW | Guard index for a swap |
| req_ptr | input | NREQ x PTR_W | New tail pointer for a swap |
| req_ready | output | NREQ | Grant: the request is accepted at this edge |
| rsp_valid | output | NREQ | One-hot response strobe, one cycle after the grant |
| rsp_ok | output | 1 | 1 = operation done, 0 = swap on an unallocated guard |
| rsp_data | output | PTR_W | Old tail pointer (swap) or new guard index (create) |
| guard_alloc | output | NGUARD | Allocation bit for each guard |
| guards_full | output | 1 | All guards allocated |

## Verification
Two situations can fall in the same cycle. In the first, two or more requesters contend for one guard: arbitration and the read-modify-write of the tail meet. The bench provokes this by holding swap requests from all requesters on one guard at once and dropping each one after its response. It judges the grant order against the round-robin rule, and it judges each returned pointer against the pointer written by the previous grant. In the second, a create is refused while the pool is full and a swap from another requester is granted in that same cycle. The bench checks both the ready pattern and the single response.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_HOLD = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/gsu_rr_arb.sv
module gsu_rr_arb #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] prio_q;

    always_comb begin
        grant = '0;
        any   = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(prio_q) + k) % N;
            if (!any && req[idx]) begin
                grant[idx] = 1'b1;
                any        = 1'b1;
                win        = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= '0;
        else if (any)
            prio_q <= IW'((int'(win) + 1) % N);
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R7
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any && req[(int'(win) + 1) % N]) |=> $past(win) != win || !any || N == 1);
endmodule

// File: rtl/gsu_guard_file.sv
module gsu_guard_file #(
    parameter int unsigned NGUARD = 8,
    parameter int unsigned PTR_W  = 64,
    parameter int unsigned GW     = (NGUARD > 1) ? $clog2(NGUARD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic              op_create,
    input  logic [GW-1:0]     op_guard,
    input  logic [PTR_W-1:0]  op_ptr,
    output logic              res_ok,
    output logic [PTR_W-1:0]  res_data,
    output logic [NGUARD-1:0] alloc,
    output logic              full
);
    logic [NGUARD-1:0]            alloc_q;
    logic [NGUARD-1:0][PTR_W-1:0] tail_q;
    logic [GW-1:0]                free_idx;
    logic                         hit;

    always_comb begin
        free_idx = '0;
        for (int g = NGUARD - 1; g >= 0; g--)
            if (!alloc_q[g]) free_idx = GW'(g);
    end

    assign full = &alloc_q;
    assign hit  = (int'(op_guard) < NGUARD) && alloc_q[op_guard];
    assign alloc = alloc_q;

    always_comb begin
        if (op_create) begin
            res_ok   = !full;
            res_data = PTR_W'(free_idx);
        end else begin
            res_ok   = hit;
            res_data = hit ? tail_q[op_guard] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '0;
            tail_q  <= '0;
        end else if (op_en) begin
            if (op_create && !full) begin
                alloc_q[free_idx] <= 1'b1;
                tail_q[free_idx]  <= '0;
            end else if (!op_create && hit) begin
                tail_q[op_guard] <= op_ptr;
            end
        end
    end

    // R2
    create_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_create && !full) |=> $countones(alloc_q) == $countones($past(alloc_q)) + 1);

    // R8
    miss_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !op_create && !hit) |=> $stable(alloc_q) && $stable(tail_q));
endmodule

// File: rtl/guard_swap_unit.sv
module guard_swap_unit
    import gsu_pkg::*;
#(
    parameter int unsigned NREQ   = 4,
    parameter int unsigned NGUARD = 8,
    parameter int unsigned PTR_W  = 64,
    parameter int unsigned GW     = (NGUARD > 1) ? $clog2(NGUARD) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREQ-1:0]               req_valid,
    input  logic [NREQ-1:0]               req_create,
    input  logic [NREQ-1:0][GW-1:0]       req_guard,
    input  logic [NREQ-1:0][PTR_W-1:0]    req_ptr,
    output logic [NREQ-1:0]               req_ready,
    output logic [NREQ-1:0]               rsp_valid,
    output logic                          rsp_ok,
    output logic [PTR_W-1:0]              rsp_data,
    output logic [NGUARD-1:0]             guard_alloc,
    output logic                          guards_full
);
    localparam int unsigned IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    rsp_state_e       state_q, state_d;
    logic [NREQ-1:0]  eligible, grant;
    logic             grant_any;
    logic [IW-1:0]    win;
    logic             res_ok;
    logic [PTR_W-1:0] res_data;
    logic [IW-1:0]    owner_q;
    logic             ok_q;
    logic [PTR_W-1:0] data_q;

    assign eligible  = req_valid & ~(req_create & {NREQ{guards_full}});
    assign req_ready = grant;

    gsu_rr_arb #(.N(NREQ), .IW(IW)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (eligible),
        .grant (grant),
        .any   (grant_any),
        .win   (win)
    );

    gsu_guard_file #(.NGUARD(NGUARD), .PTR_W(PTR_W), .GW(GW)) gfile_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_en     (grant_any),
        .op_create (req_create[win]),
        .op_guard  (req_guard[win]),
        .op_ptr    (req_ptr[win]),
        .res_ok    (res_ok),
        .res_data  (res_data),
        .alloc     (guard_alloc),
        .full      (guards_full)
    );

    always_comb state_d = grant_any ? RSP_HOLD : RSP_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            ok_q    <= 1'b0;
            data_q  <= '0;
        end else if (grant_any) begin
            owner_q <= win;
            ok_q    <= res_ok;
            data_q  <= res_data;
        end
    end

    always_comb begin
        rsp_valid = '0;
        rsp_ok    = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HOLD: begin
                rsp_valid[owner_q] = 1'b1;
                rsp_ok             = ok_q;
                rsp_data           = data_q;
            end
        endcase
    end

    // R6
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R6
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready == '0) |=> (rsp_valid == '0));

    // R9
    full_blocks_create_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guards_full |-> ((req_ready & req_create) == '0));

    // R8
    miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_valid != '0) && !rsp_ok) |-> (rsp_data == '0));

    for (genvar i = 0; i < NREQ; i++) begin : g_rsp_chk
        // R6
        rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i]) |=> rsp_valid[i]);
    end
endmodule

// File: tb/guard_swap_unit_tb.sv
`timescale 1ns/1ps
module guard_swap_unit_tb_top;
    localparam int NREQ = 4, NGUARD = 4, PTR_W = 64, GW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0]            req_valid = '0, req_create = '0;
    logic [NREQ-1:0][GW-1:0]    req_guard = '0;
    logic [NREQ-1:0][PTR_W-1:0] req_ptr = '0;
    logic [NREQ-1:0]            req_ready, rsp_valid;
    logic                       rsp_ok, guards_full;
    logic [PTR_W-1:0]           rsp_data;
    logic [NGUARD-1:0]          guard_alloc;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    guard_swap_unit #(.NREQ(NREQ), .NGUARD(NGUARD), .PTR_W(PTR_W), .GW(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_create(req_create),
        .req_guard(req_guard), .req_ptr(req_ptr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .guard_alloc(guard_alloc), .guards_full(guards_full)
    );

    typedef struct packed {
        logic [1:0]  r;
        logic        cr;
        logic [1:0]  g;
        logic [63:0] p;
        logic        ok;
        logic [63:0] d;
    } vec_t;

    localparam logic [63:0] PA = 64'hA1A1_0000_0000_0011, PB = 64'hB2B2_0000_0000_0022,
                            PC = 64'hC3C3_0000_0000_0033, PD = 64'hD4D4_0000_0000_0044,
                            PE = 64'hE5E5_0000_0000_0055, PF = 64'hF6F6_0000_0000_0066,
                            PG = 64'h1717_0000_0000_0077;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b1, 2'd0, 64'd0, 1'b1, 64'd0},
        '{2'd1, 1'b1, 2'd0, 64'd0, 1'b1, 64'd1},
        '{2'd2, 1'b0, 2'd0, PA,    1'b1, 64'd0},
        '{2'd3, 1'b0, 2'd0, PB,    1'b1, PA},
        '{2'd0, 1'b0, 2'd1, PC,    1'b1, 64'd0},
        '{2'd1, 1'b0, 2'd0, PD,    1'b1, PB},
        '{2'd2, 1'b0, 2'd3, PE,    1'b0, 64'd0},
        '{2'd3, 1'b0, 2'd1, PF,    1'b1, PC}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
        end
    end

    logic [63:0] pp [4];

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 alloc", 64'(guard_alloc), 64'd0);
        chk("R1 full", 64'(guards_full), 64'd0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);

        // R2 R3 R4 R8: one request at a time from the table
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            req_valid = '0;
            req_valid[VEC[v].r]  = 1'b1;
            req_create[VEC[v].r] = VEC[v].cr;
            req_guard[VEC[v].r]  = VEC[v].g;
            req_ptr[VEC[v].r]    = VEC[v].p;
            #1 chk($sformatf("R6 ready vec%0d", v), 64'(req_ready), 64'(1 << VEC[v].r));
            @(negedge clk);
            req_valid = '0;
            chk($sformatf("R6 rsp_valid vec%0d", v), 64'(rsp_valid), 64'(1 << VEC[v].r));
            chk($sformatf("R2/R4/R8 ok vec%0d", v), 64'(rsp_ok), 64'(VEC[v].ok));
            chk($sformatf("R2/R3/R4 data vec%0d", v), rsp_data, VEC[v].d);
        end
        chk("R8 alloc unchanged", 64'(guard_alloc), 64'b0011);
        req_create = '0;

        // R5 R7: r1 and r2 swap guard 0 together; priority sits at r0 after r3
        @(negedge clk);
        req_guard[1] = 2'd0; req_ptr[1] = PG;
        req_guard[2] = 2'd0; req_ptr[2] = 64'h2828_0000_0000_0088;
        req_valid = 4'b0110;
        #1 chk("R7 ready r1 first", 64'(req_ready), 64'b0010);
        @(negedge clk);
        chk("R6 rsp r1", 64'(rsp_valid), 64'b0010);
        chk("R5 r1 gets D", rsp_data, PD);
        req_valid[1] = 1'b0;
        @(negedge clk);
        chk("R6 rsp r2", 64'(rsp_valid), 64'b0100);
        chk("R5 r2 gets r1 ptr", rsp_data, PG);
        req_valid = '0;

        // R5 R7: all four swap guard 1, priority now at r3
        for (int i = 0; i < 4; i++) begin
            pp[i] = 64'h9000_0000_0000_0000 | 64'(i);
            req_guard[i] = 2'd1;
            req_ptr[i]   = pp[i];
        end
        @(negedge clk);
        req_valid = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            int e;
            e = (3 + k) % 4;
            @(negedge clk);
            chk($sformatf("R7 order step%0d", k), 64'(rsp_valid), 64'(1 << e));
            chk($sformatf("R5 chain step%0d", k), rsp_data, (k == 0) ? PF : pp[(e + 3) % 4]);
            req_valid[e] = 1'b0;
        end
        req_valid = '0;

        // R9: fill the pool, then create and swap in the same cycle
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            req_valid = 4'b0001; req_create = 4'b0001;
            @(negedge clk);
            req_valid = '0;
            chk($sformatf("R2 create id%0d", c + 2), rsp_data, 64'(c + 2));
        end
        chk("R9 full", 64'(guards_full), 64'd1);
        @(negedge clk);
        req_create = 4'b0001;
        req_guard[1] = 2'd1; req_ptr[1] = PE;
        req_valid = 4'b0011;
        #1 chk("R9 ready swap only", 64'(req_ready), 64'b0010);
        @(negedge clk);
        req_valid = '0; req_create = '0;
        chk("R9 rsp swap only", 64'(rsp_valid), 64'b0010);
        chk("R9 swap data", rsp_data, pp[2]);
        @(negedge clk);
        chk("R6 no grant no rsp", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        summary();
    end
endmodule